// File: doc/BRIEF.md
# Program-Window Read Bridge

This block lets a processor core read constant tables kept in instruction memory as if they sat in ordinary data memory. When the core issues a data read whose effective address falls in the upper half of data space and the window is switched on, the bridge rebuilds a program-memory address from a page register and the low address bits. It reads the 24-bit program word, returns its low 16 bits, and holds the core with a stall for the extra cycles the detour costs. Any other read is steered to data RAM through `ram_sel`.

The stall length depends on the kind of instruction and, inside a hardware repeat loop, on where the current iteration sits in the loop. A one-word prefetch register lets the middle iterations of a repeat loop that walk through consecutive words finish with no stall. A double-word move reads two consecutive program words and returns them as two results on back-to-back cycles.

The controller has three states. `ST_IDLE` accepts requests. `ST_IDLE -> ST_WAIT` happens on a window hit that needs at least one stall cycle. `ST_WAIT` counts the remaining stall cycles. `ST_WAIT -> ST_IDLE` happens when the count is used up. `ST_WAIT -> ST_SECOND` happens instead when a double-word move still owes its second result. `ST_SECOND -> ST_IDLE` always follows after one cycle. A hit that is served from the prefetch register stays in `ST_IDLE`.

Top module: `pgm_window_bridge`

## Requirements
- R1: A request is a window hit only when `req_ea[15]` is 1, the window enable is set, and `tbl_busy` is 0. Any other valid request in `ST_IDLE` raises `ram_sel` for that cycle and starts no program read.
- R2: The program address of a hit is `{1'b0, page[7:0], req_ea[14:0]}`. The address is driven on `pm_addr` with `pm_rd` high in the same cycle as the request.
- R3: `rd_data` carries bits 15:0 of the program word. Bits 23:16 never reach the output.
- R4: While `tbl_busy` is 1, a request with `req_ea[15]`=1 goes to data RAM even when the window is enabled.
- R5: Outside a repeat loop (`rpt_active`=0), the class code `req_cls` sets the stall length. Codes 1 (multiply-accumulate operand), 2 (move) and 3 (double-word move) stall for 1 cycle. Code 0 (any other class) stalls for 2 cycles.
- R6: Inside a repeat loop, an iteration flagged by `rpt_edge`=1 stalls for 2 cycles. This covers the first iteration, the last iteration, the iteration before leaving for an interrupt, and the first iteration after returning from one.
- R7: Inside a repeat loop, an iteration with `rpt_edge`=0 whose program address equals the previous window address plus 2 is served from the prefetch register. It has no stall, and `rd_valid` and the data appear in the request cycle. A mismatching address stalls for 2 cycles.
- R8: `stall` stays high for exactly the computed number of consecutive cycles. `rd_valid` pulses for one cycle on the cycle `stall` falls.
- R9: A double-word move (code 3) outside a repeat loop reads program addresses n and n+2. It returns their low halves as two `rd_valid` pulses on consecutive cycles, word n first.
- R10: A configuration write (`cfg_we`) invalidates the prefetch register. A repeat-loop iteration with `rpt_edge`=0 that follows the write stalls for 2 cycles.
- R11: Reset clears the page, the window enable, the prefetch valid flag and any pending stall. After reset `stall`, `rd_valid` and `pm_rd` are 0, and an upper-half request goes to data RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads page and window enable |
| cfg_page | input | 8 | New page value |
| cfg_en | input | 1 | New window enable value |
| req_valid | input | 1 | Data read request |
| req_ea | input | 16 | Data effective address |
| req_cls | input | 2 | Instruction class: 0 other, 1 MAC operand, 2 move, 3 double move |
| tbl_busy | input | 1 | Table read/write in progress |
| rpt_active | input | 1 | Request comes from inside a repeat loop |
| rpt_edge | input | 1 | Repeat iteration is a boundary (first, last, interrupt exit or re-entry) |
| ram_sel | output | 1 | Request steered to data RAM |
| pm_rd | output | 1 | Program memory read strobe |
| pm_addr | output | 24 | Program memory address |
| pm_rdata | input | 24 | Program word, one cycle after `pm_rd` |
| stall | output | 1 | Hold the core |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |

## Verification
Directed accesses try each instruction class outside a loop. This separates the 1-cycle and 2-cycle stall classes and checks the paired results of a double-word move. A repeat sequence then walks boundary, consecutive-middle and final iterations, which shows whether the prefetch path serves back-to-back words with zero stall. A configuration write in the middle of that walk shows that the stale prefetch is discarded. Random traffic mixes lower-half addresses, table-busy cycles, page changes and sequential or jumping repeat addresses against a bench model of the page, the enable and the prefetch. This catches errors in the hit decode, the address concatenation and the prefetch match.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
package pgw_pkg;
    typedef enum logic [1:0] {
        ACC_OTHER = 2'd0,
        ACC_MAC   = 2'd1,
        ACC_MOV   = 2'd2,
        ACC_MOVD  = 2'd3
    } acc_cls_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_SECOND = 2'd2
    } pgw_state_t;
endpackage

// File: rtl/pgw_decode.sv
`timescale 1ns/1ps
module pgw_decode #(
    parameter int EA_W   = 16,
    parameter int PAGE_W = 8,
    parameter int PA_W   = 24
) (
    input  logic [EA_W-1:0]   ea,
    input  logic              win_en,
    input  logic              tbl_busy,
    input  logic [PAGE_W-1:0] page,
    output logic              hit,
    output logic [PA_W-1:0]   pa
);
    localparam int PAD_W = PA_W - PAGE_W - (EA_W - 1);

    always_comb begin
        hit = ea[EA_W-1] && win_en && !tbl_busy;
        pa  = {{PAD_W{1'b0}}, page, ea[EA_W-2:0]};
    end
endmodule

// File: rtl/pgw_stall_calc.sv
`timescale 1ns/1ps
module pgw_stall_calc
    import pgw_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [1:0]       cls,
    input  logic             in_rpt,
    input  logic             rpt_edge,
    input  logic             pf_hit,
    output logic [CNT_W-1:0] cycles
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    always_comb begin
        if (in_rpt) begin
            cycles = (rpt_edge || !pf_hit) ? TWO : '0;
        end else begin
            unique case (acc_cls_t'(cls))
                ACC_MAC, ACC_MOV, ACC_MOVD: cycles = ONE;
                default:                    cycles = TWO;
            endcase
        end
    end
endmodule

// File: rtl/pgw_prefetch.sv
`timescale 1ns/1ps
module pgw_prefetch #(
    parameter int PA_W = 24,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            issue,
    input  logic [PA_W-1:0] issue_addr,
    input  logic [DW-1:0]   fill_data,
    output logic            pf_valid,
    output logic [PA_W-1:0] pf_addr,
    output logic [DW-1:0]   pf_word
);
    logic          fill_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
            fill_q   <= 1'b0;
            data_q   <= '0;
        end else begin
            if (fill_q) data_q <= fill_data;
            if (flush) begin
                pf_valid <= 1'b0;
                fill_q   <= 1'b0;
            end else if (issue) begin
                pf_valid <= 1'b1;
                pf_addr  <= issue_addr;
                fill_q   <= 1'b1;
            end else begin
                fill_q   <= 1'b0;
            end
        end
    end

    always_comb pf_word = fill_q ? fill_data : data_q;

    // R10
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !pf_valid);
endmodule

// File: rtl/pgm_window_bridge.sv
`timescale 1ns/1ps
module pgm_window_bridge
    import pgw_pkg::*;
#(
    parameter int EA_W   = 16,
    parameter int PAGE_W = 8,
    parameter int PA_W   = 24,
    parameter int PW_W   = 24,
    parameter int DW     = 16,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [PAGE_W-1:0] cfg_page,
    input  logic              cfg_en,
    input  logic              req_valid,
    input  logic [EA_W-1:0]   req_ea,
    input  logic [1:0]        req_cls,
    input  logic              tbl_busy,
    input  logic              rpt_active,
    input  logic              rpt_edge,
    output logic              ram_sel,
    output logic              pm_rd,
    output logic [PA_W-1:0]   pm_addr,
    input  logic [PW_W-1:0]   pm_rdata,
    output logic              stall,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data
);
    localparam logic [PA_W-1:0] WORD_STEP = PA_W'(2);

    pgw_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [PAGE_W-1:0] page_q;
    logic              en_q;
    logic [PA_W-1:0]   base_q;
    logic              movd_q, rpt_q, pfd_q, main_q;
    logic [DW-1:0]     data_q;

    logic              hit;
    logic [PA_W-1:0]   pa;
    logic              pf_valid;
    logic [PA_W-1:0]   pf_addr;
    logic [DW-1:0]     pf_word;
    logic [CNT_W-1:0]  n_cyc;
    logic              start, fast;
    logic              pf_issue;
    logic [PA_W-1:0]   pf_issue_addr;

    pgw_decode #(.EA_W(EA_W), .PAGE_W(PAGE_W), .PA_W(PA_W)) u_dec (
        .ea(req_ea), .win_en(en_q), .tbl_busy(tbl_busy), .page(page_q),
        .hit(hit), .pa(pa)
    );

    pgw_stall_calc #(.CNT_W(CNT_W)) u_calc (
        .cls(req_cls), .in_rpt(rpt_active), .rpt_edge(rpt_edge),
        .pf_hit(pf_valid && (pf_addr == pa)), .cycles(n_cyc)
    );

    pgw_prefetch #(.PA_W(PA_W), .DW(DW)) u_pf (
        .clk(clk), .rst_n(rst_n), .flush(cfg_we), .issue(pf_issue),
        .issue_addr(pf_issue_addr), .fill_data(pm_rdata[DW-1:0]),
        .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_word(pf_word)
    );

    always_comb begin
        start = (state_q == ST_IDLE) && req_valid && hit && (n_cyc != '0);
        fast  = (state_q == ST_IDLE) && req_valid && hit && (n_cyc == '0);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_WAIT;
            ST_WAIT:   if (cnt_q == '0) state_d = movd_q ? ST_SECOND : ST_IDLE;
            ST_SECOND: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            page_q <= '0;
            en_q   <= 1'b0;
            base_q <= '0;
            movd_q <= 1'b0;
            rpt_q  <= 1'b0;
            pfd_q  <= 1'b0;
            main_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (cfg_we) begin
                page_q <= cfg_page;
                en_q   <= cfg_en;
            end
            main_q <= start;
            if (main_q) data_q <= pm_rdata[DW-1:0];
            if (start) begin
                cnt_q  <= n_cyc - CNT_W'(1);
                base_q <= pa;
                movd_q <= (acc_cls_t'(req_cls) == ACC_MOVD) && !rpt_active;
                rpt_q  <= rpt_active;
                pfd_q  <= 1'b0;
            end else if (state_q == ST_WAIT) begin
                if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
                if (rpt_q) pfd_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ram_sel       = 1'b0;
        pm_rd         = 1'b0;
        pm_addr       = base_q;
        stall         = 1'b0;
        rd_valid      = 1'b0;
        rd_data       = data_q;
        pf_issue      = 1'b0;
        pf_issue_addr = base_q + WORD_STEP;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && !hit) begin
                    ram_sel = 1'b1;
                end else if (fast) begin
                    rd_valid      = 1'b1;
                    rd_data       = pf_word;
                    pm_rd         = 1'b1;
                    pm_addr       = pa + WORD_STEP;
                    pf_issue      = 1'b1;
                    pf_issue_addr = pa + WORD_STEP;
                end else if (start) begin
                    pm_rd   = 1'b1;
                    pm_addr = pa;
                    stall   = 1'b1;
                end
            end
            ST_WAIT: begin
                stall = (cnt_q != '0);
                if (rpt_q && !pfd_q) begin
                    pm_rd    = 1'b1;
                    pm_addr  = base_q + WORD_STEP;
                    pf_issue = 1'b1;
                end
                if (cnt_q == '0) begin
                    rd_valid = 1'b1;
                    rd_data  = main_q ? pm_rdata[DW-1:0] : data_q;
                    if (movd_q) begin
                        pm_rd   = 1'b1;
                        pm_addr = base_q + WORD_STEP;
                    end
                end
            end
            ST_SECOND: begin
                rd_valid = 1'b1;
                rd_data  = pm_rdata[DW-1:0];
            end
            default: ;
        endcase
    end

    // R8
    valid_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> rd_valid);

    // R8
    stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && $past(stall)) |-> ##1 !stall);

    // R1
    ram_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel |-> (!stall && !pm_rd && !rd_valid));

    // R4
    tbl_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && tbl_busy && req_valid) |-> (ram_sel && !pm_rd));

    // R2
    addr_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && stall) |->
            (pm_addr[EA_W-2:0] == req_ea[EA_W-2:0] && pm_addr[PAGE_W+EA_W-2:EA_W-1] == page_q));
endmodule

// File: tb/sim_pgm_window_bridge.sv
`timescale 1ns/1ps
module sim_pgm_window_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_page = '0;
    logic        cfg_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_ea = '0;
    logic [1:0]  req_cls = '0;
    logic        tbl_busy = 1'b0;
    logic        rpt_active = 1'b0;
    logic        rpt_edge = 1'b0;
    logic        ram_sel, pm_rd, stall, rd_valid;
    logic [23:0] pm_addr;
    logic [23:0] pm_rdata = '0;
    logic [15:0] rd_data;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [7:0]  m_page = '0;
    logic        m_en = 1'b0;
    logic        m_pfv = 1'b0;
    logic [23:0] m_pfa = '0;

    pgm_window_bridge u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_page(cfg_page), .cfg_en(cfg_en),
        .req_valid(req_valid), .req_ea(req_ea), .req_cls(req_cls), .tbl_busy(tbl_busy),
        .rpt_active(rpt_active), .rpt_edge(rpt_edge), .ram_sel(ram_sel), .pm_rd(pm_rd),
        .pm_addr(pm_addr), .pm_rdata(pm_rdata), .stall(stall), .rd_valid(rd_valid),
        .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    function automatic logic [23:0] word_of(input logic [23:0] a);
        return {a[7:0] ^ 8'h3C, a[15:0] ^ {a[23:16], 8'h5A}};
    endfunction

    function automatic logic [23:0] pa_of(input logic [7:0] pg, input logic [15:0] ea);
        return {1'b0, pg, ea[14:0]};
    endfunction

    function automatic int exp_n(input logic [1:0] cls, input bit rp, input bit ed, input bit pfh);
        if (rp) return (ed || !pfh) ? 2 : 0;
        return (cls == 2'd0) ? 2 : 1;
    endfunction

    // memory model: one-cycle read latency
    always @(posedge clk) if (pm_rd) pm_rdata <= word_of(pm_addr);

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=hung expected=done");
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [7:0] pg, input logic en);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_page = pg; cfg_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
        m_page = pg; m_en = en; m_pfv = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic access(input logic [15:0] ea, input logic [1:0] cls, input bit tb,
                          input bit rp, input bit ed, input string tag);
        logic        hit;
        logic [23:0] pa, w;
        int          expn, n;
        hit  = ea[15] && m_en && !tb;
        pa   = pa_of(m_page, ea);
        expn = exp_n(cls, rp, ed, m_pfv && (m_pfa == pa));
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_cls = cls;
        tbl_busy = tb; rpt_active = rp; rpt_edge = ed;
        #1;
        chk(ram_sel == !hit, {tag, " R1 ram select"}, ram_sel, !hit);
        if (!hit) begin
            chk(!pm_rd && !stall, {tag, " R1 R4 no program read"}, {pm_rd, stall}, 0);
            return;
        end
        if (expn > 0) chk(pm_addr == pa, {tag, " R2 address"}, pm_addr, pa);
        else          chk(pm_addr == pa + 24'd2, {tag, " R7 refill address"}, pm_addr, pa + 24'd2);
        n = 0;
        while (stall && n < 6) begin
            n++;
            @(negedge clk);
            req_valid = 1'b0;
            #1;
        end
        chk(n == expn, {tag, " R5 R6 R7 R8 stall length"}, n, expn);
        w = word_of(pa);
        chk(rd_valid && rd_data == w[15:0], {tag, " R3 R8 data"}, {rd_valid, rd_data}, {1'b1, w[15:0]});
        if (cls == 2'd3 && !rp) begin
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            w = word_of(pa + 24'd2);
            chk(rd_valid && rd_data == w[15:0], {tag, " R9 second word"}, {rd_valid, rd_data}, {1'b1, w[15:0]});
        end
        if (rp) begin
            m_pfv = 1'b1;
            m_pfa = pa + 24'd2;
        end
    endtask

    initial begin
        int seed;
        logic [15:0] last_ea;
        seed = $urandom(32'h5EED1234);
        repeat (3) @(negedge clk);
        #1;
        chk(!stall && !rd_valid && !pm_rd, "R11 reset outputs", {stall, rd_valid, pm_rd}, 0);
        rst_n = 1'b1;
        access(16'h8000, 2'd2, 0, 0, 0, "R11 window off after reset");
        idle();

        cfg(8'h05, 1'b1);
        access(16'h8010, 2'd2, 0, 0, 0, "R5 move");
        access(16'h8012, 2'd1, 0, 0, 0, "R5 mac");
        access(16'hC020, 2'd0, 0, 0, 0, "R5 other");
        access(16'h7FF0, 2'd2, 0, 0, 0, "R1 lower half");
        access(16'h8000, 2'd2, 1, 0, 0, "R4 table busy");
        idle();
        access(16'h8100, 2'd3, 0, 0, 0, "R9 double move");

        access(16'h9000, 2'd1, 0, 1, 1, "R6 first iteration");
        access(16'h9002, 2'd1, 0, 1, 0, "R7 middle");
        access(16'h9004, 2'd1, 0, 1, 0, "R7 middle back to back");
        access(16'h9010, 2'd1, 0, 1, 0, "R7 middle jump");
        access(16'h9012, 2'd1, 0, 1, 1, "R6 last iteration");
        idle();
        cfg(8'h05, 1'b1);
        access(16'h9014, 2'd1, 0, 1, 0, "R10 after config write");
        idle();
        cfg(8'hA3, 1'b1);
        access(16'hFFFE, 2'd2, 0, 0, 0, "R2 page A3");

        last_ea = 16'h8000;
        for (int i = 0; i < 300; i++) begin
            logic [15:0] ea;
            bit rp, ed, tb;
            if ($urandom % 12 == 0) begin
                cfg(8'($urandom), ($urandom % 4) != 0);
            end
            rp = ($urandom % 2) == 1;
            ed = ($urandom % 3) == 0;
            tb = ($urandom % 8) == 0;
            if (rp && ($urandom % 3) != 0) ea = last_ea + 16'd2;
            else ea = {($urandom % 4) != 0, 15'($urandom)};
            ea[0] = 1'b0;
            access(ea, 2'($urandom), tb, rp, ed, "R1 R5 R6 R7 random");
            if (ea[15] && m_en && !tb) last_ea = ea;
        end
        idle();
        summary();
        $finish;
    end
endmodule